// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. A host writes a data word of up to nine bits. The word goes into a one-entry holding buffer and then into a shift register, which sends it on a single serial line as a frame: a start bit, the data bits, an optional parity bit and one or two stop bits. Because the holding buffer can take the next word while the current frame is still on the line, frames can follow one another with no idle time between them.

Bit timing comes from an external baud tick. One bit lasts a fixed number of ticks, and double-speed mode halves that number. Two status outputs drive the host's interrupt logic. One reports that the holding buffer can take a word. The other reports that the line has gone idle after the last queued frame. The frame format and the speed are read from the configuration inputs when a frame is loaded into the shift register, so changing them while a frame is being sent does not affect that frame.

Top module: `buffered_serial_tx`

## Requirements
- R1: While reset is active, and right after it is released, `txd` is high, `dataEmpty` is high and `txDone` is low.
- R2: Every frame begins with one low start bit. The data bits follow, least-significant bit first. The number of data bits is set by `cfgDataBits`: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, and codes 4 to 7 give 9 bits.
- R3: When `cfgParity[1]` is 1, a parity bit is sent right after the last data bit. With `cfgParity[0]` = 0 the parity is even (the data bits and the parity bit together hold an even number of ones). With `cfgParity[0]` = 1 the parity is odd. When `cfgParity[1]` is 0, no parity bit is sent.
- R4: A frame ends with one high stop bit, or with two when `cfgTwoStop` is 1.
- R5: Each bit lasts 16 baud ticks, or 8 baud ticks when `cfgDoubleSpeed` is 1. The start bit appears on `txd` the cycle after the clock edge at which the frame is loaded into the shift register.
- R6: `txd` is high whenever no frame is being sent.
- R7: `dataEmpty` is high exactly when the holding buffer is empty. A write (`wrEn` high) is accepted only when `dataEmpty` is high, and `dataEmpty` is low in the cycle after an accepted write.
- R8: A write made while `dataEmpty` is low is ignored: the word is not sent, and the held word is not changed.
- R9: If a word is waiting when the last stop bit ends, its start bit begins in the next cycle, with no idle bit time. A burst of back-to-back frames therefore lasts exactly the sum of their frame lengths.
- R10: `txDone` goes high in the cycle after the last stop bit ends, if no word is waiting then. It returns low in the cycle after the next accepted write.
- R11: The data width, parity, stop-bit and speed settings are captured when a frame is loaded. Changing them while the frame is being sent does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Baud tick, one pulse per tick period |
| wrEn | input | 1 | Write strobe for the holding buffer |
| wrData | input | 9 | Word to send, least-significant bit first |
| cfgDataBits | input | 3 | Data-bit count code (see R2) |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| cfgParity | input | 2 | Bit 1 enables parity, bit 0 selects odd parity |
| cfgDoubleSpeed | input | 1 | 1 = 8 ticks per bit instead of 16 |
| txd | output | 1 | Serial line, idles high |
| dataEmpty | output | 1 | Holding buffer can accept a word |
| txDone | output | 1 | Line is idle after the final frame |

## Verification
The assertions assume the block comes out of reset before any activity, and that `baudTick` and `wrEn` are levels sampled at each rising edge. No pulse width or spacing is assumed, so a tick may be held high for many cycles. The stimulus drives every input at the falling edge, so each input is stable around the rising edge. Ticks come either on every cycle or on every third cycle. Writes are issued both when the buffer is empty and on purpose when it is full. The configuration is changed in the middle of a frame, which exercises the capture of the settings at frame load.

// File: rtl/buf_tx_pkg.sv
package buf_tx_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic capture;  // take wrData into the holding buffer
    logic load;     // build a frame from the buffer into the shifter
    logic shift;    // advance the shifter by one bit
  } txStrobe_t;

endpackage

// File: rtl/tx_datapath.sv
module tx_datapath
  import buf_tx_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int MAX_FRAME = 13,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strb,
  input  logic              busy,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        cfgDataBits,
  input  logic              cfgTwoStop,
  input  logic [1:0]        cfgParity,
  output logic [IDX_W-1:0]  frameLen,
  output logic              txd
);

  logic [DATA_W-1:0]    bufData;
  logic [MAX_FRAME-1:0] shiftReg;
  logic [MAX_FRAME-1:0] frameVec;
  logic [MAX_FRAME-1:0] dataExt;
  logic [DATA_W-1:0]    dataMask;
  logic [IDX_W-1:0]     nBits;
  logic                 parEn;
  logic                 parBit;

  assign parEn   = cfgParity[1];
  assign dataExt = {{(MAX_FRAME-DATA_W){1'b1}}, bufData};

  always_comb begin
    if (cfgDataBits >= 3'd4) nBits = IDX_W'(DATA_W);
    else                     nBits = IDX_W'(cfgDataBits) + IDX_W'(5);
  end

  // Only the bits that are actually sent count towards parity
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      dataMask[i] = (IDX_W'(i) < nBits);
    end
  end

  assign parBit = (^(bufData & dataMask)) ^ cfgParity[0];

  // Bit 0 is the first bit on the line
  always_comb begin
    for (int j = 0; j < MAX_FRAME; j++) begin
      if (j == 0)                                      frameVec[j] = 1'b0;
      else if (IDX_W'(j - 1) < nBits)                  frameVec[j] = dataExt[j-1];
      else if (parEn && (IDX_W'(j) == nBits + IDX_W'(1))) frameVec[j] = parBit;
      else                                             frameVec[j] = 1'b1;
    end
  end

  assign frameLen = IDX_W'(1) + nBits + IDX_W'(parEn) + (cfgTwoStop ? IDX_W'(2) : IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufData  <= '0;
      shiftReg <= '1;
    end else begin
      if (strb.capture) bufData <= wrData;
      if (strb.load)       shiftReg <= frameVec;
      else if (strb.shift) shiftReg <= {1'b1, shiftReg[MAX_FRAME-1:1]};
    end
  end

  assign txd = busy ? shiftReg[0] : 1'b1;

endmodule

// File: rtl/tx_control.sv
module tx_control
  import buf_tx_pkg::*;
#(
  parameter int TICKS_NORMAL = 16,
  parameter int TICKS_DOUBLE = 8,
  parameter int CNT_W        = 4,
  parameter int IDX_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baudTick,
  input  logic             wrEn,
  input  logic             cfgDoubleSpeed,
  input  logic [IDX_W-1:0] frameLen,
  output txStrobe_t        strb,
  output logic             busy,
  output logic             dataEmpty,
  output logic             txDone
);

  localparam logic [CNT_W-1:0] LAST_NORMAL = CNT_W'(TICKS_NORMAL - 1);
  localparam logic [CNT_W-1:0] LAST_DOUBLE = CNT_W'(TICKS_DOUBLE - 1);

  logic             bufValid;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastTick;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             bitEnd;
  logic             frameEnd;
  logic             accept;
  logic             loadNow;

  always_comb begin
    bitEnd       = busy && baudTick && (tickCnt == lastTick);
    frameEnd     = bitEnd && (bitIdx == lastIdx);
    accept       = wrEn && !bufValid;
    loadNow      = bufValid && (!busy || frameEnd);
    strb.capture = accept;
    strb.load    = loadNow;
    strb.shift   = bitEnd && !frameEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufValid <= 1'b0;
      busy     <= 1'b0;
      tickCnt  <= '0;
      lastTick <= LAST_NORMAL;
      bitIdx   <= '0;
      lastIdx  <= '0;
      txDone   <= 1'b0;
    end else begin
      if (accept)       bufValid <= 1'b1;
      else if (loadNow) bufValid <= 1'b0;

      if (loadNow) begin
        busy     <= 1'b1;
        tickCnt  <= '0;
        bitIdx   <= '0;
        lastIdx  <= frameLen - IDX_W'(1);
        lastTick <= cfgDoubleSpeed ? LAST_DOUBLE : LAST_NORMAL;
      end else begin
        if (frameEnd) busy <= 1'b0;
        if (busy && baudTick) tickCnt <= bitEnd ? '0 : tickCnt + CNT_W'(1);
        if (strb.shift) bitIdx <= bitIdx + IDX_W'(1);
      end

      if (accept)                     txDone <= 1'b0;
      else if (frameEnd && !bufValid) txDone <= 1'b1;
    end
  end

  assign dataEmpty = !bufValid;

endmodule

// File: rtl/buffered_serial_tx.sv
module buffered_serial_tx
  import buf_tx_pkg::*;
#(
  parameter int DATA_W       = 9,
  parameter int TICKS_NORMAL = 16,
  parameter int TICKS_DOUBLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        cfgDataBits,
  input  logic              cfgTwoStop,
  input  logic [1:0]        cfgParity,
  input  logic              cfgDoubleSpeed,
  output logic              txd,
  output logic              dataEmpty,
  output logic              txDone
);

  localparam int MAX_FRAME = DATA_W + 4;
  localparam int IDX_W     = $clog2(MAX_FRAME + 1);
  localparam int MAX_TICKS = (TICKS_NORMAL > TICKS_DOUBLE) ? TICKS_NORMAL : TICKS_DOUBLE;
  localparam int CNT_W     = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;

  txStrobe_t        strb;
  logic             shifterBusy;
  logic [IDX_W-1:0] frameLen;

  tx_control #(
    .TICKS_NORMAL(TICKS_NORMAL),
    .TICKS_DOUBLE(TICKS_DOUBLE),
    .CNT_W       (CNT_W),
    .IDX_W       (IDX_W)
  ) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .baudTick      (baudTick),
    .wrEn          (wrEn),
    .cfgDoubleSpeed(cfgDoubleSpeed),
    .frameLen      (frameLen),
    .strb          (strb),
    .busy          (shifterBusy),
    .dataEmpty     (dataEmpty),
    .txDone        (txDone)
  );

  tx_datapath #(
    .DATA_W   (DATA_W),
    .MAX_FRAME(MAX_FRAME),
    .IDX_W    (IDX_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .busy       (shifterBusy),
    .wrData     (wrData),
    .cfgDataBits(cfgDataBits),
    .cfgTwoStop (cfgTwoStop),
    .cfgParity  (cfgParity),
    .frameLen   (frameLen),
    .txd        (txd)
  );

endmodule

// File: rtl/buffered_serial_tx_chk.sv
module buffered_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baudTick,
  input logic wrEn,
  input logic busy,
  input logic txd,
  input logic dataEmpty,
  input logic txDone
);

  // R6: the line is high whenever no frame is in flight
  assert_idle_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R2: a frame opens with a low start bit
  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R5: without a tick the current bit is held
  assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baudTick) |=> (busy && $stable(txd)));

  // R7: an accepted write fills the buffer
  assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && dataEmpty) |=> !dataEmpty);

  // R10: completion only with nothing pending
  assert_done_means_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    txDone |-> dataEmpty);

  // R10: completion only at a tick that ends the last bit
  assert_done_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txDone) |-> $past(baudTick));

  // R10: a write clears completion
  assert_write_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txDone && wrEn) |=> !txDone);

endmodule

bind buffered_serial_tx buffered_serial_tx_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .baudTick (baudTick),
  .wrEn     (wrEn),
  .busy     (shifterBusy),
  .txd      (txd),
  .dataEmpty(dataEmpty),
  .txDone   (txDone)
);

// File: tb/buffered_serial_tx_tb_top.sv
module buffered_serial_tx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic [2:0] cfgDataBits = 3'd3;
  logic       cfgTwoStop = 1'b0;
  logic [1:0] cfgParity = 2'b00;
  logic       cfgDoubleSpeed = 1'b0;
  logic       txd, dataEmpty, txDone;

  buffered_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .wrEn(wrEn), .wrData(wrData),
    .cfgDataBits(cfgDataBits), .cfgTwoStop(cfgTwoStop), .cfgParity(cfgParity),
    .cfgDoubleSpeed(cfgDoubleSpeed), .txd(txd), .dataEmpty(dataEmpty), .txDone(txDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  int    tickMode = 0;
  int    tickDiv = 0;
  int    cycles = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Tick source: every cycle, or every third cycle
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 3;
    baudTick <= (tickMode == 0) ? 1'b1 : (tickDiv == 0);
  end

  // ---------------- behavioural reference ----------------
  int         bitQ[$];
  int         tagQ[$];
  bit         mBusy, mPend, mDone;
  logic [8:0] mPendData;
  int         mTcnt, mPer, mLoads;

  task automatic buildFrame(input logic [8:0] d);
    int n, ones;
    n = (cfgDataBits >= 3'd4) ? 9 : int'(cfgDataBits) + 5;
    ones = 0;
    bitQ.push_back(0); tagQ.push_back(2);
    for (int i = 0; i < n; i++) begin
      bitQ.push_back(int'(d[i])); tagQ.push_back(2);
      ones += int'(d[i]);
    end
    if (cfgParity[1]) begin
      bitQ.push_back((ones % 2) ^ int'(cfgParity[0])); tagQ.push_back(3);
    end
    bitQ.push_back(1); tagQ.push_back(4);
    if (cfgTwoStop) begin
      bitQ.push_back(1); tagQ.push_back(4);
    end
    mPer = cfgDoubleSpeed ? 8 : 16;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      bitQ.delete(); tagQ.delete();
      mBusy = 0; mPend = 0; mDone = 0; mTcnt = 0; mPer = 16; mLoads = 0;
    end else begin
      bit accept, finishing, preP;
      accept = wrEn && !mPend;
      preP = mPend;
      finishing = 0;
      if (mBusy && baudTick) begin
        mTcnt++;
        if (mTcnt == mPer) begin
          mTcnt = 0;
          void'(bitQ.pop_front()); void'(tagQ.pop_front());
          if (bitQ.size() == 0) finishing = 1;
        end
      end
      if (finishing) mBusy = 0;
      if (!mBusy && mPend) begin
        buildFrame(mPendData);
        mBusy = 1; mPend = 0; mTcnt = 0; mLoads++;
      end
      if (accept) begin mPend = 1; mPendData = wrData; end
      if (accept) mDone = 0;
      else if (finishing && !preP) mDone = 1;
    end
  end

  // Compare against the reference on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int expT;
      string tg;
      expT = mBusy ? bitQ[0] : 1;
      if (!mBusy) tg = "R6";
      else if (tagQ[0] == 2) tg = "R2";
      else if (tagQ[0] == 3) tg = "R3";
      else tg = "R4";
      check(txd == expT, tg, {curReq, " txd"}, int'(txd), expT);
      check(dataEmpty == !mPend, "R7", {curReq, " dataEmpty"}, int'(dataEmpty), int'(!mPend));
      check(txDone == mDone, "R10", {curReq, " txDone"}, int'(txDone), int'(mDone));
    end
  end

  // ---------------- helpers ----------------
  task automatic sendWord(input logic [8:0] d);
    int guard = 0;
    @(negedge clk);
    while (!dataEmpty && guard < 20000) begin @(negedge clk); guard++; end
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic forceWrite(input logic [8:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitDone();
    int guard = 0;
    @(negedge clk);
    while (!txDone && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  task automatic measureBurst(output int cnt);
    int guard = 0;
    @(negedge clk);
    while (txd && guard < 20000) begin @(negedge clk); guard++; end
    cnt = 0;
    while (!txDone && cnt < 20000) begin @(negedge clk); cnt++; end
  endtask

  task automatic measureStart(output int cnt);
    int guard = 0;
    @(negedge clk);
    while (txd && guard < 20000) begin @(negedge clk); guard++; end
    cnt = 0;
    while (!txd && cnt < 20000) begin @(negedge clk); cnt++; end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int cnt, loads0;
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
    check(dataEmpty == 1'b1, "R1", "reset dataEmpty", int'(dataEmpty), 1);
    check(txDone == 1'b0, "R1", "reset txDone", int'(txDone), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && dataEmpty && !txDone, "R1", "after release", int'({txd, dataEmpty, txDone}), 6);

    // R2: 8 data bits, no parity, one stop
    curReq = "R2";
    tickMode = 0;
    sendWord(9'h0A5);
    check(dataEmpty == 1'b0 || txd == 1'b0, "R7", "buffer taken after write", int'(dataEmpty), 0);
    waitDone();
    check(txDone == 1'b1, "R10", "done after frame", int'(txDone), 1);
    check(txd == 1'b1, "R6", "idle after frame", int'(txd), 1);

    // R10: a write clears completion
    curReq = "R10";
    sendWord(9'h1FF);
    check(txDone == 1'b0, "R10", "done cleared by write", int'(txDone), 0);
    waitDone();

    // R5: start bit length, normal and double speed
    curReq = "R5";
    fork sendWord(9'h0FF); measureStart(cnt); join
    check(cnt == 16, "R5", "start bit cycles normal", cnt, 16);
    waitDone();
    cfgDoubleSpeed = 1'b1;
    fork sendWord(9'h0FF); measureStart(cnt); join
    check(cnt == 8, "R5", "start bit cycles double", cnt, 8);
    waitDone();
    cfgDoubleSpeed = 1'b0;

    // R3/R4: parity modes and stop bits, slow ticks
    curReq = "R3";
    tickMode = 1;
    cfgDataBits = 3'd2; cfgParity = 2'b10; cfgTwoStop = 1'b1;
    sendWord(9'h053);
    waitDone();
    cfgDataBits = 3'd0; cfgParity = 2'b11; cfgTwoStop = 1'b0;
    sendWord(9'h1E6);
    waitDone();
    curReq = "R4";
    cfgDataBits = 3'd5; cfgParity = 2'b11; cfgTwoStop = 1'b1;
    sendWord(9'h10B);
    waitDone();
    check(txDone == 1'b1, "R4", "nine bits, parity, two stops complete", int'(txDone), 1);

    // R8: a write into a full buffer is dropped
    curReq = "R8";
    cfgDataBits = 3'd3; cfgParity = 2'b00; cfgTwoStop = 1'b0;
    loads0 = mLoads;
    sendWord(9'h011);
    sendWord(9'h022);
    check(dataEmpty == 1'b0, "R8", "buffer full before extra write", int'(dataEmpty), 0);
    forceWrite(9'h033);
    waitDone();
    check(mLoads - loads0 == 2, "R8", "frames sent", mLoads - loads0, 2);

    // R9: three back-to-back frames of 10 bits at 16 ticks
    curReq = "R9";
    tickMode = 0;
    sendWord(9'h081);
    fork
      begin sendWord(9'h042); sendWord(9'h024); end
      measureBurst(cnt);
    join
    check(cnt == 480, "R9", "burst length cycles", cnt, 480);

    // R11: settings changed in mid-frame do not affect it
    curReq = "R11";
    fork
      sendWord(9'h0C3);
      begin
        measureStart(cnt);
        cfgDataBits = 3'd0; cfgParity = 2'b11; cfgTwoStop = 1'b1; cfgDoubleSpeed = 1'b1;
        cnt = 16;
        while (!txDone && cnt < 20000) begin @(negedge clk); cnt++; end
      end
    join
    check(cnt == 160, "R11", "frame length cycles after config change", cnt, 160);
    sendWord(9'h015);
    waitDone();

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule